// File: doc/BRIEF.md
# PHY Channel Ownership Arbiter

This block decides which requester may use each PHY channel and which of its two PHY functions the channel is routed to. Requesters present claim and release commands, each naming a channel and a PHY index. A claim on a free channel takes the channel and rewrites that channel's select field in a shared 32-bit control word. A claim on a channel that is already taken is refused as busy until some requester releases the channel. Commands with an out-of-range channel or PHY index are refused as invalid and change nothing.

Each requester has its own command port with a valid/ready pair. Ready is low while reset is asserted and for the first cycle after it. After that it stays high, so the block never applies back-pressure. A command is taken on a clock edge where valid and ready are both high. The response is a one-cycle strobe with a status code on the next cycle, and it cannot be stalled. Commands taken in the same cycle are applied in requester-index order, lowest first. Each one sees the ownership and the control word that the lower-indexed commands of that cycle left behind, so no grant can overwrite another grant's field.

Top module: `phy_sel_top`

## Requirements
- R1: After reset, every channel is free, `ctrl_word` equals the `CTRL_INIT` parameter and no `rsp_valid` bit is set.
- R2: A command taken at a clock edge gives exactly one cycle of `rsp_valid` for that requester, starting right after that edge. Status codes are 00 = ok, 01 = busy and 10 = invalid, and 11 never appears.
- R3: A command with a channel of 3 or more, or a PHY index of 2 or more, returns invalid. It changes neither ownership nor `ctrl_word`.
- R4: A claim (`cmd_release` = 0) on a free valid channel returns ok and marks the channel as taken.
- R5: A claim on a taken channel returns busy whatever its PHY index, and leaves `ctrl_word` unchanged.
- R6: A release (`cmd_release` = 1) on a valid channel returns ok and frees it, whether or not it was taken. It leaves `ctrl_word` unchanged, and a later claim on that channel succeeds.
- R7: A grant on channel 0 writes bits 5:4 of `ctrl_word`: 01 for PHY 0 (PCI host path), 11 for PHY 1 (high-speed USB). Bits 30:6 and 3:0 never change.
- R8: A grant on channel 2 writes bit 31 of `ctrl_word`: 0 for PHY 0 (PCI host path), 1 for PHY 1 (USB 3.0 path).
- R9: Channel 1 has an empty select field. A grant on it is tracked for ownership but changes no bit of `ctrl_word`.
- R10: When claims from several requesters reach the same free channel in one cycle, the lowest requester index gets ok and the others get busy.
- R11: Grants on different channels in the same cycle all take effect in `ctrl_word`.
- R12: Within a cycle, commands on the same channel apply in ascending requester order. A lower-indexed release followed by a higher-indexed claim grants the claim. A lower-indexed claim followed by a higher-indexed release leaves the channel free.
- R13: `cmd_ready` is high in every cycle from the second clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NUM_REQ | Per-requester command valid |
| cmd_ready | output | NUM_REQ | Per-requester command ready |
| cmd_release | input | NUM_REQ | Per-requester opcode: 0 claim, 1 release |
| cmd_chan | input | NUM_REQ*CHAN_W | Per-requester channel index |
| cmd_phy | input | NUM_REQ*PHY_W | Per-requester PHY index |
| rsp_valid | output | NUM_REQ | Per-requester one-cycle response strobe |
| rsp_status | output | NUM_REQ*2 | Per-requester status code |
| ctrl_word | output | 32 | Shared general control word |

## Verification
The bench builds the block with three requesters rather than the default two. This allows two claims to compete for one channel while a third command works on another channel, and it allows a release and a claim on the same channel in the same cycle. `CTRL_INIT` is set to a pattern with many bits outside the select fields set, so any write that spills outside the fields shows up. The two select fields start clear, so setting a field and then clearing part of it can both be seen.

// File: rtl/phy_sel_pkg.sv
package phy_sel_pkg;

  localparam int unsigned NUM_CH      = 3;
  localparam int unsigned PHYS_PER_CH = 2;
  localparam int unsigned CTRL_W      = 32;
  localparam int unsigned ST_W        = 2;

  typedef enum logic [ST_W-1:0] {
    ST_OK      = 2'b00,
    ST_BUSY    = 2'b01,
    ST_INVALID = 2'b10
  } status_e;

  // Bits of the control word owned by a channel's select field.
  function automatic logic [CTRL_W-1:0] sel_mask(input int unsigned ch);
    case (ch)
      0:       sel_mask = 32'h0000_0030;
      2:       sel_mask = 32'h8000_0000;
      default: sel_mask = '0;
    endcase
  endfunction

  // Value placed in the select field for a given PHY function.
  function automatic logic [CTRL_W-1:0] sel_value(input int unsigned ch, input logic phy_hi);
    case (ch)
      0:       sel_value = phy_hi ? 32'h0000_0030 : 32'h0000_0010;
      2:       sel_value = phy_hi ? 32'h8000_0000 : 32'h0000_0000;
      default: sel_value = '0;
    endcase
  endfunction

endpackage

// File: rtl/phy_sel_decode.sv
module phy_sel_decode
  import phy_sel_pkg::*;
#(
  parameter int unsigned CHAN_W = 2,
  parameter int unsigned PHY_W  = 2
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [PHY_W-1:0]  phy,
  output logic              legal
);

  localparam logic [CHAN_W-1:0] CH_LIMIT  = CHAN_W'(NUM_CH);
  localparam logic [PHY_W-1:0]  PHY_LIMIT = PHY_W'(PHYS_PER_CH);

  always_comb begin
    legal = (chan < CH_LIMIT) && (phy < PHY_LIMIT);
  end

endmodule

// File: rtl/phy_sel_arbiter.sv
module phy_sel_arbiter
  import phy_sel_pkg::*;
#(
  parameter int unsigned NUM_REQ = 2,
  parameter int unsigned CHAN_W  = 2,
  parameter int unsigned PHY_W   = 2
) (
  input  logic [NUM_REQ-1:0]        take,
  input  logic [NUM_REQ-1:0]        release_op,
  input  logic [NUM_REQ-1:0]        legal,
  input  logic [NUM_REQ*CHAN_W-1:0] chan,
  input  logic [NUM_REQ*PHY_W-1:0]  phy,
  input  logic [NUM_CH-1:0]         owned_q,
  input  logic [CTRL_W-1:0]         word_q,
  output logic [NUM_CH-1:0]         owned_d,
  output logic [CTRL_W-1:0]         word_d,
  output logic [NUM_REQ*ST_W-1:0]   status
);

  // Commands are applied in ascending requester order; each one sees the
  // state left by the ones before it in the same cycle.
  always_comb begin
    int unsigned ch;
    owned_d = owned_q;
    word_d  = word_q;
    status  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      ch = legal[i] ? int'(chan[i*CHAN_W +: CHAN_W]) : 0;
      status[i*ST_W +: ST_W] = ST_OK;
      if (take[i]) begin
        if (!legal[i]) begin
          status[i*ST_W +: ST_W] = ST_INVALID;
        end else if (release_op[i]) begin
          owned_d[ch] = 1'b0;
        end else if (owned_d[ch]) begin
          status[i*ST_W +: ST_W] = ST_BUSY;
        end else begin
          owned_d[ch] = 1'b1;
          word_d = (word_d & ~sel_mask(ch)) | sel_value(ch, phy[i*PHY_W]);
        end
      end
    end
  end

endmodule

// File: rtl/phy_sel_top.sv
module phy_sel_top
  import phy_sel_pkg::*;
#(
  parameter int unsigned  NUM_REQ   = 2,
  parameter int unsigned  CHAN_W    = 2,
  parameter int unsigned  PHY_W     = 2,
  parameter logic [31:0]  CTRL_INIT = 32'h0000_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        cmd_valid,
  output logic [NUM_REQ-1:0]        cmd_ready,
  input  logic [NUM_REQ-1:0]        cmd_release,
  input  logic [NUM_REQ*CHAN_W-1:0] cmd_chan,
  input  logic [NUM_REQ*PHY_W-1:0]  cmd_phy,
  output logic [NUM_REQ-1:0]        rsp_valid,
  output logic [NUM_REQ*2-1:0]      rsp_status,
  output logic [31:0]               ctrl_word
);

  localparam int unsigned RSP_W = NUM_REQ * ST_W;

  logic                 ready_q;
  logic [NUM_REQ-1:0]   take;
  logic [NUM_REQ-1:0]   legal;
  logic [NUM_CH-1:0]    owned_q;
  logic [NUM_CH-1:0]    owned_d;
  logic [CTRL_W-1:0]    word_q;
  logic [CTRL_W-1:0]    word_d;
  logic [RSP_W-1:0]     status_d;
  logic [NUM_REQ-1:0]   rsp_valid_q;
  logic [RSP_W-1:0]     rsp_status_q;

  assign take = cmd_valid & {NUM_REQ{ready_q}};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    phy_sel_decode #(
      .CHAN_W (CHAN_W),
      .PHY_W  (PHY_W)
    ) u_dec (
      .chan  (cmd_chan[g*CHAN_W +: CHAN_W]),
      .phy   (cmd_phy[g*PHY_W +: PHY_W]),
      .legal (legal[g])
    );
  end

  phy_sel_arbiter #(
    .NUM_REQ (NUM_REQ),
    .CHAN_W  (CHAN_W),
    .PHY_W   (PHY_W)
  ) u_arb (
    .take       (take),
    .release_op (cmd_release),
    .legal      (legal),
    .chan       (cmd_chan),
    .phy        (cmd_phy),
    .owned_q    (owned_q),
    .word_q     (word_q),
    .owned_d    (owned_d),
    .word_d     (word_d),
    .status     (status_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q      <= 1'b0;
      owned_q      <= '0;
      word_q       <= CTRL_INIT;
      rsp_valid_q  <= '0;
      rsp_status_q <= '0;
    end else begin
      ready_q      <= 1'b1;
      owned_q      <= owned_d;
      word_q       <= word_d;
      rsp_valid_q  <= take;
      rsp_status_q <= status_d;
    end
  end

  assign cmd_ready  = {NUM_REQ{ready_q}};
  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign ctrl_word  = word_q;

endmodule

// File: rtl/phy_sel_checker.sv
module phy_sel_checker #(
  parameter int unsigned NUM_REQ   = 2,
  parameter logic [31:0] CTRL_INIT = 32'h0000_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_REQ-1:0]   cmd_valid,
  input logic [NUM_REQ-1:0]   cmd_ready,
  input logic [NUM_REQ-1:0]   rsp_valid,
  input logic [NUM_REQ*2-1:0] rsp_status,
  input logic [31:0]          ctrl_word
);

  logic any_ok;
  always_comb begin
    any_ok = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (rsp_valid[i] && rsp_status[i*2 +: 2] == 2'b00) any_ok = 1'b1;
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assert_rsp_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[g] |-> $past(cmd_valid[g] & cmd_ready[g]));
    assert_status_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[g] |-> rsp_status[g*2 +: 2] != 2'b11);
  end

  assert_reset_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_word == CTRL_INIT && rsp_valid == '0));

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ok |-> ctrl_word == $past(ctrl_word));

  assert_other_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[30:6] == $past(ctrl_word[30:6])) && (ctrl_word[3:0] == $past(ctrl_word[3:0])));

  assert_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> &cmd_ready);

endmodule

bind phy_sel_top phy_sel_checker #(
  .NUM_REQ   (NUM_REQ),
  .CTRL_INIT (CTRL_INIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .ctrl_word  (ctrl_word)
);

// File: tb/test_phy_sel_top.sv
module test_phy_sel_top;

  localparam int NR = 3;
  localparam int CW = 2;
  localparam int PW = 2;
  localparam logic [31:0] INIT = 32'h7F5A_A3CF;
  localparam logic [1:0] OK = 2'b00, BUSY = 2'b01, INV = 2'b10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NR-1:0]   cmd_valid = '0;
  logic [NR-1:0]   cmd_ready;
  logic [NR-1:0]   cmd_release = '0;
  logic [NR*CW-1:0] cmd_chan = '0;
  logic [NR*PW-1:0] cmd_phy = '0;
  logic [NR-1:0]   rsp_valid;
  logic [NR*2-1:0] rsp_status;
  logic [31:0]     ctrl_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_word = INIT;
  logic [1:0]  est [NR];

  always #5 clk = ~clk;

  phy_sel_top #(
    .NUM_REQ (NR), .CHAN_W (CW), .PHY_W (PW), .CTRL_INIT (INIT)
  ) i_phy_sel_top (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_release (cmd_release), .cmd_chan (cmd_chan), .cmd_phy (cmd_phy),
    .rsp_valid (rsp_valid), .rsp_status (rsp_status), .ctrl_word (ctrl_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int r, input bit rel, input int c, input int p, input logic [1:0] st);
    cmd_valid[r] = 1'b1;
    cmd_release[r] = rel;
    cmd_chan[r*CW +: CW] = CW'(c);
    cmd_phy[r*PW +: PW] = PW'(p);
    est[r] = st;
  endtask

  function automatic void grant(input int c, input int p);
    if (c == 0) exp_word[5:4] = p[0] ? 2'b11 : 2'b01;
    if (c == 2) exp_word[31] = p[0];
  endfunction

  // Called just after a negedge with commands set up.
  task automatic step(input string req);
    logic [NR-1:0] sent;
    sent = cmd_valid;
    @(posedge clk); #1;
    for (int r = 0; r < NR; r++) begin
      chk(rsp_valid[r] == sent[r], "R2", $sformatf("%s rsp_valid req%0d", req, r),
          32'(rsp_valid[r]), 32'(sent[r]));
      if (sent[r])
        chk(rsp_status[r*2 +: 2] == est[r], req, $sformatf("status req%0d", r),
            32'(rsp_status[r*2 +: 2]), 32'(est[r]));
    end
    chk(ctrl_word == exp_word, req, "ctrl_word", ctrl_word, exp_word);
    @(negedge clk);
    cmd_valid = '0;
    @(posedge clk); #1;
    chk(rsp_valid == '0, "R2", $sformatf("%s strobe width", req), 32'(rsp_valid), 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(rsp_valid == '0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(ctrl_word == INIT, "R1", "ctrl_word in reset", ctrl_word, INIT);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(cmd_ready == '1, "R13", "cmd_ready", 32'(cmd_ready), 32'(3'b111));
    chk(ctrl_word == INIT, "R1", "ctrl_word after reset", ctrl_word, INIT);
  endtask

  task automatic t_invalid;
    put(0, 0, 3, 0, INV); step("R3");
    put(1, 0, 0, 2, INV); step("R3");
    put(2, 1, 3, 1, INV); step("R3");
    // channel 0 still free after invalid commands
    put(0, 0, 0, 1, OK); grant(0, 1); step("R4");
  endtask

  task automatic t_busy;
    put(1, 0, 0, 0, BUSY); step("R5");
    put(0, 0, 0, 1, BUSY); step("R5");
  endtask

  task automatic t_release;
    put(1, 1, 0, 0, OK); step("R6");
    put(1, 1, 0, 1, OK); step("R6");
    put(2, 0, 0, 0, OK); grant(0, 0); step("R7");
  endtask

  task automatic t_ch2;
    put(0, 0, 2, 1, OK); grant(2, 1); step("R8");
    put(1, 1, 2, 0, OK); step("R6");
    put(1, 0, 2, 0, OK); grant(2, 0); step("R8");
  endtask

  task automatic t_ch1;
    put(2, 0, 1, 1, OK); step("R9");
    put(0, 0, 1, 0, BUSY); step("R9");
  endtask

  task automatic t_tie;
    put(0, 1, 0, 0, OK); put(1, 1, 2, 0, OK); put(2, 1, 1, 0, OK); step("R6");
    put(0, 0, 0, 1, OK); put(2, 0, 0, 0, BUSY); grant(0, 1); step("R10");
    put(1, 0, 0, 0, BUSY); step("R10");
  endtask

  task automatic t_parallel;
    put(0, 1, 0, 0, OK); step("R6");
    put(1, 0, 0, 0, OK); put(2, 0, 2, 1, OK); grant(0, 0); grant(2, 1); step("R11");
  endtask

  task automatic t_order;
    put(0, 1, 2, 0, OK); put(1, 0, 2, 0, OK); grant(2, 0); step("R12");
    put(0, 0, 1, 1, OK); put(1, 1, 1, 0, OK); step("R12");
    put(2, 0, 1, 0, OK); step("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_invalid();
    t_busy();
    t_release();
    t_ch2();
    t_ch1();
    t_tie();
    t_parallel();
    t_order();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule